// File: doc/BRIEF.md
# Power-State Command Controller for a PMIC Serial Bus

This block lets software send one power-state command (reset, sleep, shutdown or wakeup) over a power-management serial bus. The command can go to a single slave or to the broadcast group. Software first writes a one-hot mask to the group-enable register. It then writes a control word that holds the command and the target ID. That write raises busy and presents one request to the downstream bus engine. The request carries the command, the target ID and a flag that tells the engine whether the target is a group or a single slave.

When the mask selects only the broadcast group, the block ignores the ID that software wrote and uses the fixed group ID instead. The bus engine answers each accepted request with one response that is either an ACK or a NACK. That response ends the command. The result appears in two adjacent status bits that software polls.

Top module: `opstate_cmd_ctrl`

## Requirements
- R1: After reset, the status, group-enable and control registers all read 0, and reqValid is 0.
- R2: The group-enable register sits at offset 0x04. It holds a 16-bit mask in bits [15:0], and its upper bits read 0. It is writable at any time.
- R3: A write to the control register (offset 0x00) while idle launches a command. From the next cycle, status bit 0 (busy) is 1 and reqValid is 1. reqCmd carries wdata[7:4]: reset=0, sleep=1, shutdown=2, wakeup=3. reqTarget carries wdata[3:0]. reqGroup is 0 unless the R4 condition holds.
- R4: If the group-enable mask equals exactly 0x800 when a command launches, reqTarget is 11 and reqGroup is 1, whatever wdata[3:0] holds. A read of the control register then returns {cmd, 4'd11} in bits [7:0].
- R5: reqValid and the request fields stay stable until a cycle in which reqReady is 1. reqValid is 0 in the cycle after that one.
- R6: After the request is accepted, a response with rspValid=1 and rspNack=0 clears busy from the next cycle, and status bit 1 stays 0.
- R7: A NACK response (rspValid=1, rspNack=1) clears busy and sets status bit 1. Bit 1 stays set until the next command launches, which clears it.
- R8: A control write made while busy is ignored. The control readback, the request fields and the status all stay unchanged.
- R9: rspValid is ignored while no request is waiting for a response, that is, when idle or before reqReady has accepted the request.
- R10: The status register (offset 0x08) holds busy in bit 0 and NACK in bit 1, and all its other bits read 0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| reqValid | output | 1 | Downstream request pending |
| reqReady | input | 1 | Bus engine takes the request |
| reqCmd | output | 4 | Power-state command code |
| reqTarget | output | 4 | Slave or group ID |
| reqGroup | output | 1 | 1 when the target is the broadcast group |
| rspValid | input | 1 | Response from the bus engine |
| rspNack | input | 1 | Response is a NACK |

## Verification
Busy, reqValid and the request fields all change in the cycle after the control-write edge. reqValid drops one cycle after the edge at which reqReady is seen. The status bits settle one cycle after the response edge. Register reads are combinational and show the registered state at once. The bench drives every input just after a falling edge and samples 1 ns later, so each check falls exactly one rising edge after its stimulus. A scoreboard queues the request expected for each launch, and a monitor pops and compares it on the cycle where reqValid and reqReady are both high.

// File: rtl/opstate_pkg.sv
package opstate_pkg;
  localparam int CTRL_OFS = 'h00;
  localparam int GRPEN_OFS = 'h04;
  localparam int STAT_OFS = 'h08;

  typedef enum logic [1:0] {
    CMD_RESET = 2'd0,
    CMD_SLEEP = 2'd1,
    CMD_SHUTDOWN = 2'd2,
    CMD_WAKEUP = 2'd3
  } opCmd_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic launch;
    logic finish;
    logic busy;
  } opStrobes_t;
endpackage

// File: rtl/opstate_ctrl.sv
module opstate_ctrl
  import opstate_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic ctrlWrHit,
  input  logic reqReady,
  input  logic rspValid,
  output logic reqValid,
  output opStrobes_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} state_e;
  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    strb = '0;
    unique case (state)
      ST_IDLE: if (ctrlWrHit) begin
        stateNext = ST_REQ;
        strb.launch = 1'b1;
      end
      ST_REQ: if (reqReady) stateNext = ST_WAIT;
      ST_WAIT: if (rspValid) begin
        stateNext = ST_IDLE;
        strb.finish = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
    strb.busy = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  assign reqValid = (state == ST_REQ);

  assert_launch_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && ctrlWrHit) |=> (reqValid && strb.busy));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> reqValid);
  assert_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqValid);
  assert_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && rspValid) |=> !strb.busy);
  assert_early_rsp_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REQ && rspValid && !reqReady) |=> (strb.busy && reqValid));
endmodule

// File: rtl/opstate_datapath.sv
module opstate_datapath
  import opstate_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NUM_IDS = 16,
  parameter int CMD_W = 4,
  parameter int BCAST_ID = 11,
  localparam int ID_W = $clog2(NUM_IDS)
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  opStrobes_t strb,
  input  logic rspNack,
  output logic ctrlWrHit,
  output logic [CMD_W-1:0] reqCmd,
  output logic [ID_W-1:0] reqTarget,
  output logic reqGroup
);
  localparam logic [NUM_IDS-1:0] BCAST_MASK = NUM_IDS'(1) << BCAST_ID;

  logic [NUM_IDS-1:0] grpMask;
  logic [CMD_W-1:0] cmdReg;
  logic [ID_W-1:0] tgtReg;
  logic grpFlag, nackFlag, isBcast, grpWrHit;
  logic unusedWdata;

  assign unusedWdata = ^regWdata;
  assign ctrlWrHit = regWrEn && (regAddr == ADDR_W'(CTRL_OFS));
  assign grpWrHit = regWrEn && (regAddr == ADDR_W'(GRPEN_OFS));
  assign isBcast = (grpMask == BCAST_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) grpMask <= '0;
    else if (grpWrHit) grpMask <= regWdata[NUM_IDS-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
      tgtReg <= '0;
      grpFlag <= 1'b0;
    end else if (strb.launch) begin
      cmdReg <= regWdata[ID_W +: CMD_W];
      tgtReg <= isBcast ? ID_W'(BCAST_ID) : regWdata[ID_W-1:0];
      grpFlag <= isBcast;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nackFlag <= 1'b0;
    else if (strb.launch) nackFlag <= 1'b0;
    else if (strb.finish) nackFlag <= rspNack;
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(CTRL_OFS)) regRdata = DATA_W'({cmdReg, tgtReg});
    else if (regAddr == ADDR_W'(GRPEN_OFS)) regRdata = DATA_W'(grpMask);
    else if (regAddr == ADDR_W'(STAT_OFS)) regRdata = DATA_W'({nackFlag, strb.busy});
  end

  assign reqCmd = cmdReg;
  assign reqTarget = tgtReg;
  assign reqGroup = grpFlag;

  assert_bcast_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.launch && isBcast) |=> (reqTarget == ID_W'(BCAST_ID) && reqGroup));
  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrHit && strb.busy) |=> ($stable(reqTarget) && $stable(reqCmd) && $stable(reqGroup)));
  assert_nack_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> (nackFlag == $past(rspNack)));
  assert_nack_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (nackFlag && !strb.launch) |=> nackFlag);
endmodule

// File: rtl/opstate_cmd_ctrl.sv
module opstate_cmd_ctrl
  import opstate_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NUM_IDS = 16,
  parameter int CMD_W = 4,
  parameter int BCAST_ID = 11,
  localparam int ID_W = $clog2(NUM_IDS)
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic reqValid,
  input  logic reqReady,
  output logic [CMD_W-1:0] reqCmd,
  output logic [ID_W-1:0] reqTarget,
  output logic reqGroup,
  input  logic rspValid,
  input  logic rspNack
);
  opStrobes_t strb;
  logic ctrlWrHit;

  opstate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWrHit(ctrlWrHit), .reqReady(reqReady),
    .rspValid(rspValid), .reqValid(reqValid), .strb(strb)
  );

  opstate_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_IDS(NUM_IDS),
    .CMD_W(CMD_W), .BCAST_ID(BCAST_ID)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strb(strb), .rspNack(rspNack),
    .ctrlWrHit(ctrlWrHit), .reqCmd(reqCmd), .reqTarget(reqTarget), .reqGroup(reqGroup)
  );
endmodule

// File: tb/test_opstate_cmd_ctrl.sv
module test_opstate_cmd_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic reqValid, reqGroup;
  logic reqReady = 1'b0;
  logic [3:0] reqCmd, reqTarget;
  logic rspValid = 1'b0;
  logic rspNack = 1'b0;

  int errors = 0;
  int checks = 0;
  logic [8:0] expQ[$];

  always #10 clk = ~clk;

  opstate_cmd_ctrl i_opstate_cmd_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .reqValid(reqValid),
    .reqReady(reqReady), .reqCmd(reqCmd), .reqTarget(reqTarget),
    .reqGroup(reqGroup), .rspValid(rspValid), .rspNack(rspNack)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic issue(input logic [3:0] c, input logic [3:0] t,
                       input logic [3:0] expT, input logic expG);
    logic [31:0] s;
    expQ.push_back({c, expT, expG});
    wr(8'h00, {24'h0, c, t});
    #1;
    rd(8'h08, s);
    chk("R3", "status after launch", s, 32'h1);
    chk("R3", "reqValid after launch", {31'h0, reqValid}, 32'h1);
  endtask

  task automatic accept();
    @(negedge clk); reqReady = 1'b1;
    @(negedge clk); reqReady = 1'b0;
    #1;
    chk("R5", "reqValid after accept", {31'h0, reqValid}, 32'h0);
  endtask

  task automatic respond(input logic n);
    @(negedge clk); rspValid = 1'b1; rspNack = n;
    @(negedge clk); rspValid = 1'b0; rspNack = 1'b0;
    #1;
  endtask

  // scoreboard monitor
  always begin
    @(negedge clk);
    #1;
    if (rstN && reqValid && reqReady) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 unexpected request: actual=0x%0h expected=none",
                 {reqCmd, reqTarget, reqGroup});
      end else begin
        logic [8:0] e;
        e = expQ.pop_front();
        chk("R3/R4", "request fields", {23'h0, reqCmd, reqTarget, reqGroup}, {23'h0, e});
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    rd(8'h08, v); chk("R1", "status at reset", v, 0);
    rd(8'h04, v); chk("R1", "group mask at reset", v, 0);
    rd(8'h00, v); chk("R1", "control at reset", v, 0);
    chk("R1", "reqValid at reset", {31'h0, reqValid}, 0);
    rd(8'h3C, v); chk("R10", "unmapped offset", v, 0);

    wr(8'h04, 32'hFFFF_0010);
    rd(8'h04, v); chk("R2", "group mask readback", v, 32'h10);

    // individual target, shutdown to slave 5
    issue(4'd2, 4'd5, 4'd5, 1'b0);
    chk("R3", "reqCmd", {28'h0, reqCmd}, 2);
    chk("R3", "reqTarget", {28'h0, reqTarget}, 5);
    chk("R3", "reqGroup", {31'h0, reqGroup}, 0);
    respond(1'b1);
    rd(8'h08, v); chk("R9", "early response ignored", v, 32'h1);
    repeat (2) @(negedge clk);
    #1;
    chk("R5", "reqValid held", {31'h0, reqValid}, 1);
    wr(8'h00, 32'h31);
    #1;
    rd(8'h00, v); chk("R8", "control kept while busy", v, 32'h25);
    rd(8'h08, v); chk("R8", "status kept while busy", v, 32'h1);
    chk("R8", "target kept while busy", {28'h0, reqTarget}, 5);
    accept();
    respond(1'b0);
    rd(8'h08, v); chk("R6", "status after ACK", v, 0);

    // broadcast group, wakeup
    wr(8'h04, 32'h800);
    reqReady = 1'b1;
    issue(4'd3, 4'd4, 4'd11, 1'b1);
    rd(8'h00, v); chk("R4", "control shows group id", v, 32'h3B);
    chk("R4", "reqGroup", {31'h0, reqGroup}, 1);
    @(negedge clk); reqReady = 1'b0;
    respond(1'b1);
    rd(8'h08, v); chk("R7", "status after NACK", v, 32'h2);
    repeat (3) @(negedge clk);
    #1;
    rd(8'h08, v); chk("R7", "NACK sticky", v, 32'h2);
    respond(1'b0);
    rd(8'h08, v); chk("R9", "idle response ignored", v, 32'h2);

    // mask with extra bit is not broadcast
    wr(8'h04, 32'h801);
    issue(4'd1, 4'd9, 4'd9, 1'b0);
    rd(8'h08, v); chk("R7", "NACK cleared on launch", v, 32'h1);
    accept();
    respond(1'b0);

    wr(8'h04, 32'h0);
    for (int c = 0; c < 4; c++) begin
      issue(4'(c), 4'(15 - c), 4'(15 - c), 1'b0);
      accept();
      respond(1'b0);
      rd(8'h08, v); chk("R6", "status after command", v, 0);
    end

    chk("R3", "scoreboard drained", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule